// File: doc/BRIEF.md
# Banked Multi-Width Register File

This block holds a 64-byte register file that a datapath reaches through a register-operand port, one read and one write per cycle, as bytes, 16-bit words or 32-bit dwords. The lowest eight register indices are banked. A two-bit bank-select input chooses which of four 8-byte banks they resolve to. Register indices 8 to 31 and the two dwords at indices 56 and 60 are fixed storage, the same in every bank.

A second, byte-wide port exposes the whole banked area (all four banks, active or not) as memory addresses 00h to 1Fh. The dword at index 56 carries an extended data pointer. Its least significant byte selects the external memory region and resets to 01h. A separate byte-wide special-register port also reads and writes that byte, over the same storage as the register path.

Top module: `banked_regfile`

## Requirements
- R1: After reset every byte reads 00h, except the region-select byte (least significant byte of dword 56), which reads the REGION_RESET parameter (default 01h).
- R2: Register indices 0 to 7 resolve to physical byte bank_sel*8+index. This holds for bytes R0-R7, words 0-6 and dwords 0 and 4.
- R3: Register indices 8 to 31 and 56 to 63 are the same in every bank and do not appear in the memory window.
- R4: Size code 0 is byte, 1 is word and 2 is dword. Multi-byte registers are big-endian: the lowest index holds the most significant byte. Read data is right-aligned and zero-extended to 32 bits, and write data is taken from the low bits.
- R5: A request is valid for bytes 0-15, for even words 0-30, and for dwords that are multiples of 4 in 0-28 or equal to 56 or 60. An invalid read raises rd_err and returns 0. An invalid write raises wr_err and changes nothing.
- R6: The memory port reads and writes physical byte mem_addr (00h-1Fh), which is bank mem_addr[4:3], index mem_addr[2:0].
- R7: When the memory port and the register port write the same byte in one cycle, the register-port value is stored.
- R8: The special-register port reads and writes the region-select byte. If the register port writes that byte in the same cycle, the register-port value is stored.
- R9: All reads are combinational and return the contents from before any write in the same cycle. Writes take effect at the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 2 | Active bank for indices 0-7 |
| rd_size | input | 2 | Read size code |
| rd_num | input | 6 | Read register number |
| rd_data | output | 32 | Read data, right-aligned |
| rd_err | output | 1 | Read request invalid |
| wr_en | input | 1 | Register write enable |
| wr_size | input | 2 | Write size code |
| wr_num | input | 6 | Write register number |
| wr_data | input | 32 | Write data, right-aligned |
| wr_err | output | 1 | Write request invalid |
| mem_we | input | 1 | Memory-port write enable |
| mem_addr | input | 5 | Memory-port byte address |
| mem_wdata | input | 8 | Memory-port write data |
| mem_rdata | output | 8 | Memory-port read data |
| sfr_we | input | 1 | Region-select byte write enable |
| sfr_wdata | input | 8 | Region-select byte write data |
| sfr_rdata | output | 8 | Region-select byte value |

## Verification
The bench writes a word through one bank and reads it back as a dword through another bank. A design that ignored bank_sel, or swapped byte order, returns the wrong bank's bytes or reversed bytes. It writes an unbanked byte in one bank and reads it from another. A design that banked every index, or folded indices 8 and above into the window, shows zero or corrupts bank 1. Same-cycle collisions on the memory and special-register ports show which writer a wrong priority lets through. A misaligned dword write is followed by a window read of the bytes it would have overwritten. A read taken in the same cycle as a write to the same byte exposes a design that forwards the new data.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter logic [7:0] REGION_RESET = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bank_sel,
  input  logic [1:0]  rd_size,
  input  logic [5:0]  rd_num,
  output logic [31:0] rd_data,
  output logic        rd_err,
  input  logic        wr_en,
  input  logic [1:0]  wr_size,
  input  logic [5:0]  wr_num,
  input  logic [31:0] wr_data,
  output logic        wr_err,
  input  logic        mem_we,
  input  logic [4:0]  mem_addr,
  input  logic [7:0]  mem_wdata,
  output logic [7:0]  mem_rdata,
  input  logic        sfr_we,
  input  logic [7:0]  sfr_wdata,
  output logic [7:0]  sfr_rdata
);
  localparam int NBYTES     = 64;
  localparam int REGION_IDX = 59;

  logic [7:0] store [NBYTES];

  function automatic logic [5:0] phys(input logic [5:0] idx, input logic [1:0] bank);
    if (idx < 6'd8)       return {1'b0, bank, idx[2:0]};
    else if (idx < 6'd32) return idx + 6'd24;
    else                  return idx;
  endfunction

  function automatic logic req_ok(input logic [1:0] sz, input logic [5:0] num);
    case (sz)
      2'd0:    return num < 6'd16;
      2'd1:    return !num[0] && num < 6'd32;
      2'd2:    return num[1:0] == 2'b00 && (num < 6'd32 || num >= 6'd56);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int lanes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  logic [7:0] rd_byte [4];
  logic [5:0] wr_addr [4];
  logic [7:0] wr_byte [4];
  logic [3:0] wr_lane;
  logic       wr_ok;

  assign rd_err    = !req_ok(rd_size, rd_num);
  assign wr_ok     = req_ok(wr_size, wr_num);
  assign wr_err    = wr_en && !wr_ok;
  assign mem_rdata = store[{1'b0, mem_addr}];
  assign sfr_rdata = store[REGION_IDX];

  for (genvar j = 0; j < 4; j++) begin : g_lane
    assign rd_byte[j] = store[phys(6'(rd_num + 6'(j)), bank_sel)];
    assign wr_addr[j] = phys(6'(wr_num + 6'(j)), bank_sel);
    assign wr_lane[j] = wr_en && wr_ok && (j < lanes(wr_size));
    always_comb begin
      case (wr_size)
        2'd0:    wr_byte[j] = wr_data[7:0];
        2'd1:    wr_byte[j] = (j == 0) ? wr_data[15:8] : wr_data[7:0];
        default: wr_byte[j] = wr_data[8*(3-j) +: 8];
      endcase
    end
  end

  always_comb begin
    if (rd_err) rd_data = '0;
    else case (rd_size)
      2'd0:    rd_data = {24'd0, rd_byte[0]};
      2'd1:    rd_data = {16'd0, rd_byte[0], rd_byte[1]};
      default: rd_data = {rd_byte[0], rd_byte[1], rd_byte[2], rd_byte[3]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++)
        store[i] <= (i == REGION_IDX) ? REGION_RESET : 8'h00;
    end else begin
      if (mem_we) store[{1'b0, mem_addr}] <= mem_wdata;
      if (sfr_we) store[REGION_IDX] <= sfr_wdata;
      for (int j = 0; j < 4; j++)
        if (wr_lane[j]) store[wr_addr[j]] <= wr_byte[j];
    end
  end
endmodule

module banked_regfile_chk #(
  parameter logic [7:0] REGION_RESET = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bank_sel,
  input logic [1:0]  rd_size,
  input logic [5:0]  rd_num,
  input logic [31:0] rd_data,
  input logic        rd_err,
  input logic        wr_en,
  input logic [1:0]  wr_size,
  input logic [5:0]  wr_num,
  input logic [31:0] wr_data,
  input logic        wr_err,
  input logic        mem_we,
  input logic [4:0]  mem_addr,
  input logic [7:0]  mem_wdata,
  input logic [7:0]  mem_rdata,
  input logic        sfr_we,
  input logic [7:0]  sfr_wdata,
  input logic [7:0]  sfr_rdata
);
  assert_rd_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> rd_data == 32'd0);

  assert_odd_word_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_size == 2'd1 && rd_num[0]) |-> rd_err);

  assert_bad_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_err && !mem_we && !sfr_we) |=>
      ($stable(sfr_rdata) && (mem_addr != $past(mem_addr) || mem_rdata == $past(mem_rdata))));

  assert_mem_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !wr_en) |=> (mem_addr != $past(mem_addr) || mem_rdata == $past(mem_wdata)));

  assert_sfr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && !wr_en) |=> sfr_rdata == $past(sfr_wdata));

  assert_region_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> sfr_rdata == REGION_RESET);
endmodule

bind banked_regfile banked_regfile_chk #(.REGION_RESET(REGION_RESET)) chk_i (.*);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bank_sel = '0, rd_size = '0, wr_size = '0;
  logic [5:0] rd_num = '0, wr_num = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic rd_err, wr_err, wr_en = 1'b0, mem_we = 1'b0, sfr_we = 1'b0;
  logic [4:0] mem_addr = '0;
  logic [7:0] mem_wdata = '0, mem_rdata, sfr_wdata = '0, sfr_rdata;
  int compared = 0, mismatched = 0;

  always #10 clk = ~clk;

  banked_regfile dut_i (.*);

  // {write, bank, size, num, value, err}
  localparam logic [43:0] VEC [12] = '{
    {1'b1, 2'd0, 2'd2, 6'd0,  32'h11223344, 1'b0},  // R4 DR0 bank0
    {1'b0, 2'd0, 2'd0, 6'd0,  32'h00000011, 1'b0},  // R4 MSB in R0
    {1'b0, 2'd0, 2'd0, 6'd3,  32'h00000044, 1'b0},  // R4
    {1'b0, 2'd0, 2'd1, 6'd2,  32'h00003344, 1'b0},  // R4 word
    {1'b1, 2'd2, 2'd1, 6'd2,  32'h0000AABB, 1'b0},  // R2 WR2 bank2
    {1'b0, 2'd2, 2'd2, 6'd0,  32'h0000AABB, 1'b0},  // R2
    {1'b0, 2'd0, 2'd2, 6'd0,  32'h11223344, 1'b0},  // R2 bank0 untouched
    {1'b1, 2'd1, 2'd0, 6'd9,  32'h0000005A, 1'b0},  // R3 R9 from bank1
    {1'b0, 2'd3, 2'd0, 6'd9,  32'h0000005A, 1'b0},  // R3 seen from bank3
    {1'b0, 2'd3, 2'd1, 6'd8,  32'h0000005A, 1'b0},  // R3 WR8
    {1'b1, 2'd0, 2'd2, 6'd56, 32'hCAFEBEEF, 1'b0},  // R4 DR56
    {1'b0, 2'd1, 2'd1, 6'd3,  32'h00000000, 1'b1}   // R5 odd word
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] b, input logic [1:0] sz, input logic [5:0] n, input logic [31:0] d);
    @(negedge clk);
    bank_sel = b; wr_size = sz; wr_num = n; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input string req, input logic [1:0] b, input logic [1:0] sz, input logic [5:0] n,
                        input logic [31:0] exp, input logic experr);
    @(negedge clk);
    bank_sel = b; rd_size = sz; rd_num = n;
    #1;
    check(req, rd_data, exp);
    check(req, {31'd0, rd_err}, {31'd0, experr});
  endtask

  task automatic mem_rd(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk);
    mem_addr = a;
    #1;
    check(req, {24'd0, mem_rdata}, {24'd0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1", {24'd0, sfr_rdata}, 32'h01);
    reg_rd("R1", 2'd0, 2'd2, 6'd56, 32'h00000001, 1'b0);
    reg_rd("R1", 2'd0, 2'd2, 6'd60, 32'h00000000, 1'b0);
    mem_rd("R1", 5'd5, 8'h00);

    foreach (VEC[i]) begin
      if (VEC[i][43]) reg_wr(VEC[i][42:41], VEC[i][40:39], VEC[i][38:33], VEC[i][32:1]);
      else reg_rd("R2/R3/R4/R5 table", VEC[i][42:41], VEC[i][40:39], VEC[i][38:33], VEC[i][32:1], VEC[i][0]);
    end

    @(negedge clk); #1 check("R8", {24'd0, sfr_rdata}, 32'hEF);
    mem_rd("R6", 5'd18, 8'hAA);
    mem_rd("R6", 5'd0, 8'h11);

    // R6 window write reaches bank1 R1
    @(negedge clk); mem_addr = 5'd9; mem_wdata = 8'h77; mem_we = 1'b1;
    @(negedge clk); mem_we = 1'b0;
    reg_rd("R6", 2'd1, 2'd0, 6'd1, 32'h77, 1'b0);
    mem_rd("R3", 5'd1, 8'h22);

    // R7 collision
    @(negedge clk);
    mem_addr = 5'd1; mem_wdata = 8'hE1; mem_we = 1'b1;
    bank_sel = 2'd0; wr_size = 2'd0; wr_num = 6'd1; wr_data = 32'hD1; wr_en = 1'b1;
    @(negedge clk); mem_we = 1'b0; wr_en = 1'b0;
    reg_rd("R7", 2'd0, 2'd0, 6'd1, 32'hD1, 1'b0);

    // R5 misaligned dword write
    @(negedge clk);
    bank_sel = 2'd0; wr_size = 2'd2; wr_num = 6'd2; wr_data = 32'hFFFFFFFF; wr_en = 1'b1;
    #1 check("R5", {31'd0, wr_err}, 32'd1);
    @(negedge clk); wr_en = 1'b0;
    mem_rd("R5", 5'd2, 8'h33);
    mem_rd("R5", 5'd5, 8'h00);
    reg_rd("R5", 2'd0, 2'd0, 6'd16, 32'h0, 1'b1);
    reg_rd("R5", 2'd0, 2'd2, 6'd32, 32'h0, 1'b1);

    // R8 special-register port
    @(negedge clk); sfr_wdata = 8'h9C; sfr_we = 1'b1;
    @(negedge clk); sfr_we = 1'b0;
    #1 check("R8", {24'd0, sfr_rdata}, 32'h9C);
    reg_rd("R8", 2'd3, 2'd2, 6'd56, 32'hCAFEBE9C, 1'b0);
    @(negedge clk);
    sfr_wdata = 8'h55; sfr_we = 1'b1;
    bank_sel = 2'd0; wr_size = 2'd2; wr_num = 6'd56; wr_data = 32'h01020304; wr_en = 1'b1;
    @(negedge clk); sfr_we = 1'b0; wr_en = 1'b0;
    #1 check("R8", {24'd0, sfr_rdata}, 32'h04);

    // R9 read before write
    @(negedge clk);
    bank_sel = 2'd0; rd_size = 2'd0; rd_num = 6'd0;
    wr_size = 2'd0; wr_num = 6'd0; wr_data = 32'h99; wr_en = 1'b1;
    #1 check("R9", rd_data, 32'h11);
    @(negedge clk); wr_en = 1'b0;
    #1 check("R9", rd_data, 32'h99);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule